// File: doc/BRIEF.md
# Serial ADC Readout Controller

This controller sits on the host side of a 10-bit successive-approximation converter with a serial interface. On a start request it drops the active-low chip select. It waits a qualification interval and then produces exactly ten I/O clock periods by dividing the system clock. It captures one result bit on each I/O clock rising edge, most significant bit first. After the tenth clock it raises chip select, publishes the 10-bit word with a one-cycle done strobe, and keeps chip select high for the conversion interval before another frame may begin.

A start request that arrives while a frame or a conversion wait is running is remembered and served as soon as the wait ends. An abort request seen during a frame lets the tenth clock finish. The controller then lowers chip select briefly inside the abort window, skips the conversion wait and leaves the result and done outputs untouched. Every chip-select level is held long enough for the converter to recognise it.

Top module: `adc_serial_ctrl`

## Requirements
- R1: Out of reset chip select is high (inactive), the I/O clock is low, the result is 0 and done is low.
- R2: Each frame shifts in ten bits. The first bit received lands in result bit 9 and the last in bit 0, so an all-ones word reads back as 10'h3FF and an all-zeros word as 10'h000.
- R3: Done is high for exactly one system clock per completed frame, in the cycle where chip select has just returned high, and the result already holds the new word in that cycle.
- R4: A frame has exactly ten I/O clock rising edges. The I/O clock is high only while chip select is low, and each of its high and low phases inside a frame lasts HALF_DIV system clocks.
- R5: Chip select never changes level until it has held its current level for at least HOLD_CYC system clocks. The first I/O clock rise of a frame comes at least HOLD_CYC clocks after chip select falls.
- R6: After a completed frame, chip select stays high for at least CONV_CYC system clocks before the next frame starts.
- R7: If abort is high in any cycle of a frame, all ten I/O clocks still run, but done stays low and the result keeps its previous value.
- R8: After an aborted frame, chip select is high for exactly HOLD_CYC clocks after the tenth clock. It is then low for exactly HOLD_CYC clocks with no I/O clock, and it returns high.
- R9: A start pulse that arrives during a frame or during the conversion wait is not lost. It launches one further frame when the wait ends. A start held high gives back-to-back frames.
- R10: An abort request while no frame is running has no effect on the next frame.
- R11: The result changes only in a cycle where done is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request one readout frame |
| abort_i | input | 1 | Abort the conversion of the current frame |
| sdata_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Active-low chip select to the converter |
| ioclk_o | output | 1 | I/O clock to the converter |
| result_o | output | 10 | Last completed conversion word |
| done_o | output | 1 | One-cycle strobe marking a new result |

## Verification
The assertions assume that the converter changes its data line only after I/O clock falling edges or chip-select edges, so the value sampled at the rising edge is a settled bit. They also assume that start and abort are synchronous to the system clock. The bench meets this with a behavioural converter model: it loads a new word on each chip-select fall, steps to the next bit on each I/O clock fall, and drives its inputs on the falling system edge. The sweep runs all 1024 words with a small divider and short hold and wait counts, so the full timing skeleton is exercised in every frame.

// File: rtl/adc_serial_ctrl.sv
module adc_serial_ctrl #(
  parameter int HALF_DIV = 2,
  parameter int HOLD_CYC = 3,
  parameter int CONV_CYC = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       abort_i,
  input  logic       sdata_i,
  output logic       cs_n_o,
  output logic       ioclk_o,
  output logic [9:0] result_o,
  output logic       done_o
);
  localparam int NBITS = 10;
  localparam int TW = $clog2(CONV_CYC + HOLD_CYC + 1);
  localparam int PW = $clog2(2 * HALF_DIV);

  typedef enum logic [2:0] {
    S_IDLE, S_SETUP, S_SHIFT, S_CONV, S_ABHI, S_ABLO, S_REST
  } st_t;

  st_t             st;
  logic [TW-1:0]   tmr;
  logic [PW-1:0]   ph;
  logic [3:0]      nbit;
  logic [NBITS-1:0] shreg, res_q;
  logic            pend, abt, cs_q, ck_q, done_q;

  wire hit_hold = tmr == TW'(HOLD_CYC - 1);
  wire hit_conv = tmr == TW'(CONV_CYC - 1);
  wire ph_rise  = ph == PW'(HALF_DIV - 1);
  wire ph_end   = ph == PW'(2 * HALF_DIV - 1);
  wire last_bit = nbit == 4'(NBITS - 1);

  assign cs_n_o   = cs_q;
  assign ioclk_o  = ck_q;
  assign result_o = res_q;
  assign done_o   = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      tmr    <= '0;
      ph     <= '0;
      nbit   <= '0;
      shreg  <= '0;
      res_q  <= '0;
      pend   <= 1'b0;
      abt    <= 1'b0;
      cs_q   <= 1'b1;
      ck_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i && st != S_IDLE) pend <= 1'b1;
      case (st)
        S_IDLE: begin
          if (pend || start_i) begin
            st   <= S_SETUP;
            cs_q <= 1'b0;
            tmr  <= '0;
            pend <= 1'b0;
            abt  <= 1'b0;
          end
        end
        S_SETUP: begin
          if (abort_i) abt <= 1'b1;
          tmr <= tmr + 1'b1;
          if (hit_hold) begin
            st   <= S_SHIFT;
            ph   <= '0;
            nbit <= '0;
          end
        end
        S_SHIFT: begin
          if (abort_i) abt <= 1'b1;
          ph <= ph + 1'b1;
          if (ph_rise) begin
            ck_q  <= 1'b1;
            shreg <= {shreg[NBITS-2:0], sdata_i};
          end
          if (ph_end) begin
            ck_q <= 1'b0;
            ph   <= '0;
            nbit <= nbit + 1'b1;
            if (last_bit) begin
              cs_q <= 1'b1;
              tmr  <= '0;
              if (abt || abort_i) begin
                st <= S_ABHI;
              end else begin
                st     <= S_CONV;
                res_q  <= shreg;
                done_q <= 1'b1;
              end
            end
          end
        end
        S_CONV: begin
          tmr <= tmr + 1'b1;
          if (hit_conv) st <= S_IDLE;
        end
        S_ABHI: begin
          tmr <= tmr + 1'b1;
          if (hit_hold) begin
            st   <= S_ABLO;
            cs_q <= 1'b0;
            tmr  <= '0;
          end
        end
        S_ABLO: begin
          tmr <= tmr + 1'b1;
          if (hit_hold) begin
            st   <= S_REST;
            cs_q <= 1'b1;
            tmr  <= '0;
          end
        end
        S_REST: begin
          tmr <= tmr + 1'b1;
          if (hit_hold) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module adc_serial_ctrl_chk #(
  parameter int HOLD_CYC = 3,
  parameter int CONV_CYC = 12
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n_o,
  input logic       ioclk_o,
  input logic [9:0] result_o,
  input logic       done_o
);
  logic        cs_d;
  logic [15:0] held, since_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_d       <= 1'b1;
      held       <= 16'hFFFF;
      since_done <= 16'hFFFF;
    end else begin
      cs_d <= cs_n_o;
      if (cs_n_o != cs_d) held <= 16'd1;
      else if (held != 16'hFFFF) held <= held + 16'd1;
      if (done_o) since_done <= 16'd0;
      else if (since_done != 16'hFFFF) since_done <= since_done + 16'd1;
    end
  end

  AST_IOCLK_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n) ioclk_o |-> !cs_n_o); // R4
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done_o |=> !done_o); // R3
  AST_DONE_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n) done_o |-> cs_n_o); // R3
  AST_RESULT_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n) !$stable(result_o) |-> done_o); // R11
  AST_CS_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (cs_n_o != cs_d) |-> held >= 16'(HOLD_CYC)); // R5
  AST_CONV_WAIT: assert property (@(posedge clk) disable iff (!rst_n) (cs_d && !cs_n_o) |-> since_done >= 16'(CONV_CYC - 1)); // R6
endmodule

bind adc_serial_ctrl adc_serial_ctrl_chk #(.HOLD_CYC(HOLD_CYC), .CONV_CYC(CONV_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n_o(cs_n_o), .ioclk_o(ioclk_o),
  .result_o(result_o), .done_o(done_o)
);

// File: tb/adc_serial_ctrl_bench.sv
module adc_serial_ctrl_bench;
  localparam int CLK_P = 10;
  localparam int HALF = 2;
  localparam int HOLD = 3;
  localparam int CONV = 12;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, abort = 1'b0;
  logic cs_n, ioclk, done, sdata;
  logic [9:0] result;

  adc_serial_ctrl #(.HALF_DIV(HALF), .HOLD_CYC(HOLD), .CONV_CYC(CONV)) u_adc_serial_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start), .abort_i(abort), .sdata_i(sdata),
    .cs_n_o(cs_n), .ioclk_o(ioclk), .result_o(result), .done_o(done)
  );

  always #(CLK_P/2) clk = ~clk;

  int total = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [9:0] pat(input int i);
    return 10'(i * 389);
  endfunction

  // converter model
  int fidx = 0, nfall = 0;
  logic [9:0] dev_word = '0;
  always @(negedge cs_n) begin
    dev_word = pat(fidx);
    fidx++;
    nfall = 0;
  end
  always @(negedge ioclk) if (!cs_n) nfall++;
  assign sdata = (!cs_n && nfall < 10) ? dev_word[9 - nfall] : 1'b0;

  // monitor
  logic prev_cs = 1'b1, prev_ck = 1'b0, prev_done = 1'b0;
  logic [9:0] last_res = '0;
  int lvl_len = 1000, ck_len = 0, rises = 0, prev_hi = 0, donecnt = 0;
  bit done_seen = 0;

  always @(negedge clk) if (rst_n && !finished) begin
    if (done) begin
      chk(result == dev_word, "R2 result word", result, dev_word);
      chk(cs_n == 1'b1, "R3 done with cs high", cs_n, 1);
      donecnt++;
      done_seen = 1;
    end
    if (done && prev_done) chk(0, "R3 done longer than one cycle", 2, 1);
    if (result != last_res && !done) chk(0, "R11 result changed without done", result, last_res);
    last_res = result;

    if (ioclk && !prev_ck) begin
      chk(!cs_n, "R4 ioclk rise with cs low", cs_n, 0);
      if (rises == 0) chk(lvl_len >= HOLD, "R5 setup before first ioclk", lvl_len, HOLD);
      else chk(ck_len == HALF, "R4 ioclk low phase", ck_len, HALF);
      rises++;
      ck_len = 1;
    end else if (!ioclk && prev_ck) begin
      chk(ck_len == HALF, "R4 ioclk high phase", ck_len, HALF);
      ck_len = 1;
    end else ck_len++;

    if (cs_n != prev_cs) begin
      chk(lvl_len >= HOLD, "R5 cs level hold", lvl_len, HOLD);
      if (cs_n) begin
        if (rises == 0) begin
          chk(prev_hi == HOLD, "R8 high before abort pulse", prev_hi, HOLD);
          chk(lvl_len == HOLD, "R8 abort pulse width", lvl_len, HOLD);
        end else chk(rises == 10, "R4 ioclk rises per frame", rises, 10);
      end else begin
        prev_hi = lvl_len;
        if (done_seen) chk(lvl_len >= CONV, "R6 conversion wait", lvl_len, CONV);
        done_seen = 0;
        rises = 0;
      end
      lvl_len = 1;
    end else lvl_len++;
    prev_cs = cs_n;
    prev_ck = ioclk;
    prev_done = done;
  end

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int d0;
    logic [9:0] r0;
    wait_cyc(3);
    chk(cs_n == 1'b1, "R1 reset cs", cs_n, 1);
    chk(ioclk == 1'b0, "R1 reset ioclk", ioclk, 0);
    chk(result == 10'd0, "R1 reset result", result, 0);
    chk(done == 1'b0, "R1 reset done", done, 0);
    @(negedge clk) rst_n = 1'b1;
    wait_cyc(2);

    // R2 R9: every word, start held high for back-to-back frames
    start = 1'b1;
    while (donecnt < 1024) @(negedge clk);
    start = 1'b0;
    wait_cyc(150);
    chk(donecnt == 1025, "R9 held start frames", donecnt, 1025);
    chk(cs_n == 1'b1, "R9 idle after start released", cs_n, 1);

    // R10: abort while idle ignored
    d0 = donecnt;
    @(negedge clk) abort = 1'b1;
    @(negedge clk) abort = 1'b0;
    wait_cyc(5);
    pulse_start();
    wait_cyc(120);
    chk(donecnt == d0 + 1, "R10 idle abort ignored", donecnt, d0 + 1);

    // R7 R8: abort during a frame
    d0 = donecnt;
    r0 = result;
    pulse_start();
    wait_cyc(20);
    @(negedge clk) abort = 1'b1;
    @(negedge clk) abort = 1'b0;
    wait_cyc(150);
    chk(donecnt == d0, "R7 no done after abort", donecnt, d0);
    chk(result == r0, "R7 result kept after abort", result, r0);

    // R9: start during conversion wait is kept
    d0 = donecnt;
    pulse_start();
    while (donecnt == d0) @(negedge clk);
    wait_cyc(2);
    pulse_start();
    wait_cyc(150);
    chk(donecnt == d0 + 2, "R9 pending start served", donecnt, d0 + 2);

    // R9: start during the shifting phase is kept
    d0 = donecnt;
    pulse_start();
    wait_cyc(15);
    pulse_start();
    wait_cyc(200);
    chk(donecnt == d0 + 2, "R9 start mid-frame served", donecnt, d0 + 2);

    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      chk(0, "watchdog expired", 0, 1);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule